// File: doc/BRIEF.md
# Snooping MESI Line Coherence Controller

This block tracks the coherence state of a single cache line across a parameterised number of private caches (default four) that share one snooping bus. Each core raises a read or write request for the line. The block serialises requests through a fixed-priority arbiter. For the granted core it derives the bus transaction the request needs: a shared read, a read-for-ownership, an invalidating upgrade, or nothing. In the same cycle every other cache snoops that transaction and all states update at the next clock edge.

Next to the states, the block holds one data word per cache and one word standing in for main memory. With these it can return the value a reader actually observes. It flags when a dirty owner supplies its data cache-to-cache and shows which caches owe a write-back. Two counters let traffic totals be checked: one counts all bus transactions, the other counts only the transactions that move the line. A requester keeps its request raised while its stall bit is high. A request completes in the cycle it is granted.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: A read from a cache in I issues a shared read (bus_op code 1). The requester installs the line in E (state code 2) when no other cache holds a valid copy, otherwise in S (code 1). rd_data shows the dirty owner's word if a cache holds the line in M, else the memory word.
- R2: A write by a cache in E moves it to M (code 3) with bus_op 0 (none), and neither counter changes.
- R3: A write by a cache in S issues an upgrade (bus_op code 3). Every other cache ends in I (code 0), and the writer ends in M holding the written word.
- R4: A write by a cache in I issues a read-for-ownership (bus_op code 2). A cache holding the line in M raises c2c_flush with its index on flush_src. Every other cache ends in I, and the writer ends in M holding the written word.
- R5: A cache snooping a shared read moves from E or M to S. An M holder also raises c2c_flush and updates the memory word, so later readers that miss get the dirty value.
- R6: wb_owed bit i is high exactly while cache i holds the line in M.
- R7: Reads by a cache in M, E or S, and writes by a cache in M, complete with bus_op 0, leave both counters unchanged, and return the cache's own word on rd_data.
- R8: When several cores request at once, the lowest-numbered one is granted (grant_id). Every other requester has its stall bit high until it is granted in a later cycle.
- R9: At most one cache is ever in M or E, and while one is, no other cache holds a valid copy.
- R10: bus_count increments once for every transaction other than none. xfer_count increments only for shared reads and reads-for-ownership, so strictly alternating writes by two cores add one transfer per write.
- R11: After reset every cache is in I, both counters and the memory word are zero, and nothing is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | N | Per-core request, held until not stalled |
| req_write | input | N | Per-core request type, 1 = write |
| req_wdata | input | N*DW | Per-core write word, core i at bits [DW*i +: DW] |
| stall | output | N | Request present but not granted this cycle |
| grant_valid | output | 1 | A request is served this cycle |
| grant_id | output | IDW | Index of the served core |
| bus_op | output | 2 | 0 none, 1 shared read, 2 read-for-ownership, 3 upgrade |
| rd_valid | output | 1 | The served request is a read |
| rd_data | output | DW | Word returned to the served reader |
| c2c_flush | output | 1 | A dirty owner supplies the line this cycle |
| flush_src | output | IDW | Index of the supplying owner |
| wb_owed | output | N | Per-cache dirty flag |
| line_state | output | 2*N | Per-cache state, core i at bits [2*i +: 2]; I=0 S=1 E=2 M=3 |
| bus_count | output | CW | Bus transactions since reset |
| xfer_count | output | CW | Line-moving transactions since reset |

## Verification
The hardest situation to reach is a dirty owner being snooped while other caches already share the line. That needs a precise history: several readers, then an upgrade by one of them, then a new reader or a write miss from a different core. The directed scenarios build that history one request at a time. They then check which cache supplies the data, what value the reader receives, and whether memory took the dirty word. A separate scenario raises three requests at once to exercise the arbiter's stall sequence. After every request the bench confirms that the single-writer rule still holds.

// File: rtl/mesi_pkg.sv
package mesi_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } line_st_t;

  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_RD   = 2'd1,
    OP_RDX  = 2'd2,
    OP_UPGR = 2'd3
  } bus_op_t;

  // Transaction needed by a requester given its own state.
  function automatic bus_op_t pick_op(input line_st_t st, input logic wr);
    bus_op_t op;
    op = OP_NONE;
    if (!wr) begin
      if (st == ST_I) op = OP_RD;
    end else begin
      case (st)
        ST_I:    op = OP_RDX;
        ST_S:    op = OP_UPGR;
        default: op = OP_NONE;
      endcase
    end
    return op;
  endfunction

endpackage

// File: rtl/mesi_prio_arb.sv
module mesi_prio_arb #(
  parameter int N   = 4,
  parameter int IDW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [N-1:0]   req,
  output logic [N-1:0]   gnt,
  output logic           gnt_any,
  output logic [IDW-1:0] gnt_idx
);

  always_comb begin
    gnt     = '0;
    gnt_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        gnt     = '0;
        gnt[i]  = 1'b1;
        gnt_idx = IDW'(i);
      end
    end
    gnt_any = |req;
  end

  // R8: at most one grant, and only to a requester
  p_one_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(gnt) && ((gnt & ~req) == '0));

endmodule

// File: rtl/mesi_line_cell.sv
module mesi_line_cell
  import mesi_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          granted,
  input  logic          req_write,
  input  logic [DW-1:0] req_wdata,
  input  bus_op_t       bus_op,
  input  logic          others_valid,
  input  logic [DW-1:0] fill_data,
  output line_st_t      st_o,
  output logic [DW-1:0] data_o,
  output logic          supplies_o
);

  line_st_t      st_q, st_n;
  logic [DW-1:0] data_q, data_n;
  logic          upd_en;

  assign upd_en = granted || (bus_op != OP_NONE);

  always_comb begin
    st_n   = st_q;
    data_n = data_q;
    if (granted) begin
      if (req_write) begin
        st_n   = ST_M;
        data_n = req_wdata;
      end else if (st_q == ST_I) begin
        st_n   = others_valid ? ST_S : ST_E;
        data_n = fill_data;
      end
    end else begin
      case (bus_op)
        OP_RD: begin
          if (st_q == ST_M || st_q == ST_E) st_n = ST_S;
        end
        OP_RDX, OP_UPGR: st_n = ST_I;
        default: st_n = st_q;
      endcase
    end
  end

  assign supplies_o = !granted && (st_q == ST_M) &&
                      (bus_op == OP_RD || bus_op == OP_RDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_I;
      data_q <= '0;
    end else if (upd_en) begin
      st_q   <= st_n;
      data_q <= data_n;
    end
  end

  assign st_o   = st_q;
  assign data_o = data_q;

  // R1: a granted read miss always lands in a valid clean state
  p_fill_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (granted && !req_write && st_q == ST_I) |=> (st_q == ST_S || st_q == ST_E));

  // R4: a snooped read-for-ownership leaves this cache invalid
  p_rdx_kill_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!granted && bus_op == OP_RDX) |=> (st_q == ST_I));

endmodule

// File: rtl/mesi_traffic_ctr.sv
module mesi_traffic_ctr
  import mesi_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  bus_op_t       bus_op,
  output logic [CW-1:0] bus_cnt,
  output logic [CW-1:0] xfer_cnt
);

  logic          bus_en, xfer_en;
  logic [CW-1:0] bus_q, xfer_q, bus_n, xfer_n;

  assign bus_en  = (bus_op != OP_NONE);
  assign xfer_en = (bus_op == OP_RD) || (bus_op == OP_RDX);
  assign bus_n   = bus_q + CW'(1);
  assign xfer_n  = xfer_q + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_q <= '0;
    else if (bus_en) bus_q <= bus_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) xfer_q <= '0;
    else if (xfer_en) xfer_q <= xfer_n;
  end

  assign bus_cnt  = bus_q;
  assign xfer_cnt = xfer_q;

  // R10: an upgrade moves no data
  p_upgr_no_xfer_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_op == OP_UPGR) |=> $stable(xfer_q));

endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
  import mesi_pkg::*;
#(
  parameter int N   = 4,
  parameter int DW  = 8,
  parameter int CW  = 16,
  localparam int IDW = (N > 1) ? $clog2(N) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req_valid,
  input  logic [N-1:0]    req_write,
  input  logic [N*DW-1:0] req_wdata,
  output logic [N-1:0]    stall,
  output logic            grant_valid,
  output logic [IDW-1:0]  grant_id,
  output logic [1:0]      bus_op,
  output logic            rd_valid,
  output logic [DW-1:0]   rd_data,
  output logic            c2c_flush,
  output logic [IDW-1:0]  flush_src,
  output logic [N-1:0]    wb_owed,
  output logic [2*N-1:0]  line_state,
  output logic [CW-1:0]   bus_count,
  output logic [CW-1:0]   xfer_count
);

  logic [N-1:0]   gnt;
  logic           gnt_any;
  logic [IDW-1:0] gnt_idx;

  line_st_t       st      [N];
  logic [DW-1:0]  cdata   [N];
  logic [N-1:0]   supplies;
  logic [N-1:0]   valid_v;
  logic [N-1:0]   owner_v;
  logic           others_valid;
  line_st_t       g_st;
  logic           g_wr;
  bus_op_t        op;
  logic           flush_any;
  logic [IDW-1:0] flush_idx;
  logic [DW-1:0]  flush_data;
  logic [DW-1:0]  fill_data;
  logic [DW-1:0]  mem_q, mem_n;
  logic           mem_en;

  mesi_prio_arb #(.N(N), .IDW(IDW)) u_arb (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req_valid),
    .gnt     (gnt),
    .gnt_any (gnt_any),
    .gnt_idx (gnt_idx)
  );

  // Requester view
  assign g_st = st[gnt_idx];
  assign g_wr = req_write[gnt_idx];
  assign op   = gnt_any ? pick_op(g_st, g_wr) : OP_NONE;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      valid_v[i] = (st[i] != ST_I);
      owner_v[i] = (st[i] == ST_M) || (st[i] == ST_E);
    end
  end

  assign others_valid = |(valid_v & ~gnt);

  // Dirty-owner data path
  always_comb begin
    flush_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (supplies[i]) flush_idx = IDW'(i);
    end
  end

  assign flush_any  = |supplies;
  assign flush_data = cdata[flush_idx];
  assign fill_data  = flush_any ? flush_data : mem_q;

  // Per-cache state and data
  for (genvar c = 0; c < N; c++) begin : g_cell
    mesi_line_cell #(.DW(DW)) u_cell (
      .clk          (clk),
      .rst_n        (rst_n),
      .granted      (gnt[c]),
      .req_write    (req_write[c]),
      .req_wdata    (req_wdata[DW*c +: DW]),
      .bus_op       (op),
      .others_valid (others_valid),
      .fill_data    (fill_data),
      .st_o         (st[c]),
      .data_o       (cdata[c]),
      .supplies_o   (supplies[c])
    );
    assign line_state[2*c +: 2] = st[c];
    assign wb_owed[c]           = (st[c] == ST_M);
  end

  // Memory word: refreshed when a dirty owner is downgraded to shared
  assign mem_en = (op == OP_RD) && flush_any;
  assign mem_n  = flush_data;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mem_q <= '0;
    else if (mem_en) mem_q <= mem_n;
  end

  mesi_traffic_ctr #(.CW(CW)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_op   (op),
    .bus_cnt  (bus_count),
    .xfer_cnt (xfer_count)
  );

  assign stall       = req_valid & ~gnt;
  assign grant_valid = gnt_any;
  assign grant_id    = gnt_idx;
  assign bus_op      = op;
  assign rd_valid    = gnt_any && !g_wr;
  assign rd_data     = (g_st == ST_I) ? fill_data : cdata[gnt_idx];
  assign c2c_flush   = flush_any;
  assign flush_src   = flush_idx;

  // R9: single-writer invariant
  p_single_writer_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(owner_v) <= 1) &&
    ((owner_v == '0) || ($countones(valid_v) == 1)));

  // R2: silent E to M upgrade
  p_silent_upgrade_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_any && g_wr && g_st == ST_E) |=>
      ($stable(bus_count) && $stable(xfer_count) && wb_owed == $past(gnt)));

  // R3: an upgrade leaves only the writer valid
  p_upgrade_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_UPGR) |=> ((valid_v & ~$past(gnt)) == '0));

  // R5: only a dirty copy is ever supplied cache-to-cache
  p_flush_dirty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    c2c_flush |-> wb_owed[flush_src]);

  // R10: every transaction is counted once
  p_count_bus_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (op != OP_NONE) |=> (bus_count == $past(bus_count) + CW'(1)));

endmodule

// File: tb/test_mesi_snoop_ctrl.sv
module test_mesi_snoop_ctrl;

  localparam int N      = 4;
  localparam int DW     = 8;
  localparam int CW     = 16;
  localparam int IDW    = 2;
  localparam int CLK_PERIOD = 10;

  logic            clk;
  logic            rst_n;
  logic [N-1:0]    req_valid;
  logic [N-1:0]    req_write;
  logic [N*DW-1:0] req_wdata;
  logic [N-1:0]    stall;
  logic            grant_valid;
  logic [IDW-1:0]  grant_id;
  logic [1:0]      bus_op;
  logic            rd_valid;
  logic [DW-1:0]   rd_data;
  logic            c2c_flush;
  logic [IDW-1:0]  flush_src;
  logic [N-1:0]    wb_owed;
  logic [2*N-1:0]  line_state;
  logic [CW-1:0]   bus_count;
  logic [CW-1:0]   xfer_count;

  int n_vec;
  int n_bad;
  bit done;

  logic [1:0]    c_op;
  logic [DW-1:0] c_rd;
  logic          c_rdv;
  logic          c_fl;
  logic [IDW-1:0] c_src;
  logic [IDW-1:0] c_gid;

  mesi_snoop_ctrl #(.N(N), .DW(DW), .CW(CW)) i_mesi_snoop_ctrl (
    .clk (clk), .rst_n (rst_n),
    .req_valid (req_valid), .req_write (req_write), .req_wdata (req_wdata),
    .stall (stall), .grant_valid (grant_valid), .grant_id (grant_id),
    .bus_op (bus_op), .rd_valid (rd_valid), .rd_data (rd_data),
    .c2c_flush (c2c_flush), .flush_src (flush_src), .wb_owed (wb_owed),
    .line_state (line_state), .bus_count (bus_count), .xfer_count (xfer_count)
  );

  initial begin
    clk = 1'b0;
    forever #(CLK_PERIOD / 2) clk = ~clk;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] st_of(input int c);
    return line_state[2*c +: 2];
  endfunction

  // R9 check from the ports
  task automatic chk_single_writer();
    int owners;
    int valids;
    owners = 0;
    valids = 0;
    for (int i = 0; i < N; i++) begin
      if (st_of(i) >= 2'd2) owners++;
      if (st_of(i) != 2'd0) valids++;
    end
    chk("R9 single writer", 32'((owners > 1) || (owners == 1 && valids != 1)), 32'd0);
  endtask

  task automatic do_reset();
    req_valid = '0;
    req_write = '0;
    req_wdata = '0;
    rst_n     = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One request, served in one cycle; captures the combinational view
  task automatic issue(input int c, input logic wr, input logic [DW-1:0] d);
    @(negedge clk);
    req_valid = '0;
    req_write = '0;
    req_valid[c] = 1'b1;
    req_write[c] = wr;
    req_wdata[DW*c +: DW] = d;
    #1;
    c_op  = bus_op;
    c_rd  = rd_data;
    c_rdv = rd_valid;
    c_fl  = c2c_flush;
    c_src = flush_src;
    c_gid = grant_id;
    @(posedge clk);
    #1;
    req_valid = '0;
    req_write = '0;
    chk_single_writer();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R11 states after reset", 32'(line_state), 32'd0);
    chk("R11 bus_count after reset", 32'(bus_count), 32'd0);
    chk("R11 xfer_count after reset", 32'(xfer_count), 32'd0);
    chk("R11 no grant after reset", 32'(grant_valid), 32'd0);
    chk("R11 no stall after reset", 32'(stall), 32'd0);
    // memory word zero: first read miss returns 0
    issue(3, 1'b0, '0);
    chk("R11 memory word zero", 32'(c_rd), 32'd0);
  endtask

  task automatic t_share_upgrade();
    do_reset();
    issue(0, 1'b0, '0);
    chk("R1 sole reader op", 32'(c_op), 32'd1);
    chk("R1 sole reader valid", 32'(c_rdv), 32'd1);
    chk("R1 sole reader gets E", 32'(st_of(0)), 32'd2);
    issue(1, 1'b0, '0);
    chk("R5 clean E owner no flush", 32'(c_fl), 32'd0);
    chk("R1 second reader gets S", 32'(st_of(1)), 32'd1);
    chk("R5 E owner drops to S", 32'(st_of(0)), 32'd1);
    issue(0, 1'b1, 8'h07);
    chk("R3 write in S op", 32'(c_op), 32'd3);
    chk("R3 writer M", 32'(st_of(0)), 32'd3);
    chk("R3 sharer invalid", 32'(st_of(1)), 32'd0);
    chk("R6 owed after upgrade", 32'(wb_owed), 32'h1);
    chk("R10 bus count", 32'(bus_count), 32'd3);
    chk("R10 xfer count", 32'(xfer_count), 32'd2);
    issue(0, 1'b0, '0);
    chk("R3 writer holds word", 32'(c_rd), 32'h07);
  endtask

  task automatic t_silent_then_flush();
    do_reset();
    issue(0, 1'b0, '0);
    issue(0, 1'b1, 8'h05);
    chk("R2 silent op", 32'(c_op), 32'd0);
    chk("R2 state M", 32'(st_of(0)), 32'd3);
    chk("R2 bus count unchanged", 32'(bus_count), 32'd1);
    chk("R2 xfer count unchanged", 32'(xfer_count), 32'd1);
    chk("R6 owed while M", 32'(wb_owed), 32'h1);
    issue(1, 1'b0, '0);
    chk("R5 read snoops M op", 32'(c_op), 32'd1);
    chk("R5 dirty flush", 32'(c_fl), 32'd1);
    chk("R5 flush source", 32'(c_src), 32'd0);
    chk("R1 reader gets dirty word", 32'(c_rd), 32'h05);
    chk("R5 owner to S", 32'(st_of(0)), 32'd1);
    chk("R1 reader S", 32'(st_of(1)), 32'd1);
    chk("R6 nothing owed", 32'(wb_owed), 32'h0);
    chk("R10 bus count", 32'(bus_count), 32'd2);
    issue(2, 1'b0, '0);
    chk("R5 memory took dirty word", 32'(c_rd), 32'h05);
    chk("R5 no flush from S", 32'(c_fl), 32'd0);
  endtask

  task automatic t_pingpong();
    do_reset();
    for (int k = 0; k < 6; k++) begin
      int c;
      c = k % 2;
      issue(c, 1'b1, 8'(k + 1));
      chk("R4 write miss op", 32'(c_op), 32'd2);
      chk("R4 flush on ping-pong", 32'(c_fl), 32'(k > 0));
      if (k > 0) chk("R4 flush source", 32'(c_src), 32'(1 - c));
      chk("R4 writer M", 32'(st_of(c)), 32'd3);
      chk("R4 loser I", 32'(st_of(1 - c)), 32'd0);
    end
    chk("R10 ping-pong transfers", 32'(xfer_count), 32'd6);
    chk("R10 ping-pong bus ops", 32'(bus_count), 32'd6);
    issue(0, 1'b0, '0);
    chk("R1 reader sees last write", 32'(c_rd), 32'h06);
  endtask

  task automatic t_sharers();
    do_reset();
    issue(0, 1'b0, '0);
    issue(1, 1'b0, '0);
    issue(2, 1'b0, '0);
    chk("R1 three sharers", 32'(line_state), 32'h15);
    issue(1, 1'b1, 8'h09);
    chk("R3 upgrade op", 32'(c_op), 32'd3);
    chk("R3 two invalidated", 32'(line_state), 32'h0C);
    issue(3, 1'b0, '0);
    chk("R5 flush from C1", 32'(c_src), 32'd1);
    chk("R1 reader gets 9", 32'(c_rd), 32'h09);
    chk("R5 owner and reader S", 32'(line_state), 32'h44);
    issue(2, 1'b1, 8'h04);
    chk("R4 write miss over sharers op", 32'(c_op), 32'd2);
    chk("R4 no flush from S", 32'(c_fl), 32'd0);
    chk("R4 only writer valid", 32'(line_state), 32'h30);
    chk("R10 bus count", 32'(bus_count), 32'd6);
    chk("R10 xfer count", 32'(xfer_count), 32'd5);
  endtask

  task automatic t_local_hits();
    do_reset();
    issue(2, 1'b0, '0);
    issue(2, 1'b0, '0);
    chk("R7 read hit E op", 32'(c_op), 32'd0);
    issue(2, 1'b1, 8'h33);
    issue(2, 1'b0, '0);
    chk("R7 read hit M op", 32'(c_op), 32'd0);
    chk("R7 read hit M data", 32'(c_rd), 32'h33);
    issue(2, 1'b1, 8'h44);
    chk("R7 write hit M op", 32'(c_op), 32'd0);
    chk("R7 counters unchanged", 32'({bus_count, xfer_count}), 32'h0001_0001);
    issue(0, 1'b0, '0);
    chk("R5 reader gets 44", 32'(c_rd), 32'h44);
    issue(0, 1'b0, '0);
    chk("R7 read hit S op", 32'(c_op), 32'd0);
    chk("R7 read hit S data", 32'(c_rd), 32'h44);
    chk("R7 bus count after S hit", 32'(bus_count), 32'd2);
  endtask

  task automatic t_arbitration();
    do_reset();
    @(negedge clk);
    req_write = '0;
    req_valid = 4'b1110;
    #1;
    chk("R8 lowest granted", 32'(grant_id), 32'd1);
    chk("R8 others stall", 32'(stall), 32'b1100);
    @(posedge clk);
    #1;
    chk("R8 first winner E", 32'(st_of(1)), 32'd2);
    @(negedge clk);
    req_valid = 4'b1100;
    #1;
    chk("R8 next granted", 32'(grant_id), 32'd2);
    chk("R8 one stall left", 32'(stall), 32'b1000);
    @(posedge clk);
    #1;
    @(negedge clk);
    req_valid = 4'b1000;
    #1;
    chk("R8 last granted", 32'(grant_id), 32'd3);
    chk("R8 no stall", 32'(stall), 32'b0000);
    @(posedge clk);
    #1;
    req_valid = '0;
    chk("R8 all three share", 32'(line_state), 32'h54);
    chk("R10 three reads counted", 32'(xfer_count), 32'd3);
    chk_single_writer();
  endtask

  initial begin
    n_vec = 0;
    n_bad = 0;
    done  = 1'b0;
    t_reset();
    t_share_upgrade();
    t_silent_then_flush();
    t_pingpong();
    t_sharers();
    t_local_hits();
    t_arbitration();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule